// File: doc/BRIEF.md
# Low-Power Regulator Sequencing Controller

This block sequences the two regulators that feed a chip's core supply. One is a main regulator for normal running and the other is a standby regulator with very low quiescent current. It also derives the power reset, the brown-out response and the low-voltage response. The analog comparators are outside the block. They reach it as asynchronous level flags: the supply is above the power-on level, the supply is at or below the power-down level, the supply is at or below the brown-out level, and the supply is below the low-voltage threshold. The external active-low reset pin is also asynchronous. All five signals pass through a two-flop synchronizer before any logic uses them.

A five-state machine tracks the power situation. The states are OFF, RUN, SLEEP, DS1 and DS2. From RUN, a one-cycle sleep request with a mode code enters a power-saving state. Plain sleep leaves the regulators as they are. Both deep-sleep states turn the main regulator off and hand the core over to the standby regulator in low-current mode. In DS2, a configuration bit decides whether the standby regulator stays on to retain core data. Several events return the machine to RUN, but only while the supply is above the power-on level: a wakeup request, a falling edge on the reset pin, or (from OFF only) brown-out detection enabled with a healthy supply. A power-down detection overrides everything.

Brown-out can cause a reset or an interrupt. Low voltage can cause an interrupt or a wakeup. Interrupt causes are kept in sticky flags with write-one-to-clear inputs.

Top module: `lp_reg_sequencer`

## Requirements
- R1: Each comparator flag and the reset pin act through a two-flop synchronizer. A change applied between clock edges reaches the outputs just after the second following edge.
- R2: While the synchronized power-down flag is 1, the main enable and the standby enable are both 0. On the next edge the state becomes OFF.
- R3: OFF is left for RUN only when the synchronized power-on flag is 1 and one of these holds: a wakeup source is active, a reset-pin falling edge is seen, or brown-out enable is 1 with the brown-out flag at 0.
- R4: Mode code 0 enters SLEEP. In SLEEP the regulator outputs are the same as in RUN.
- R5: Mode code 1 enters DS1. In DS1 the main enable is 0, the standby enable is 1 and the low-current flag is 1.
- R6: Mode codes 2 and 3 enter DS2. In DS2 the main enable is 0, and the standby enable and the low-current flag both equal the standby-on configuration bit.
- R7: In RUN and SLEEP the regulator mode follows the off bit and the low-current bit. Off 0 with low-current 0 gives main on and standby off. Off 0 with low-current 1 gives main off, and standby on with the low-current flag at 1. Off 1 gives both regulators off.
- R8: From SLEEP, DS1 or DS2, with the power-on flag at 1, any of these returns the state to RUN on the next edge: a wakeup request (bit 0 timer, bit 1 external line, bit 2 wake pin), a low-voltage wakeup, or a reset-pin falling edge. `wake_evt` is high for exactly that first RUN cycle.
- R9: `sys_rst` is 1 in any of these cases: in OFF, while power-down is flagged, while the power-on flag is 0, or when brown-out enable is 1 with interrupt-select 0 and brown-out flagged.
- R10: With brown-out enable 1 and interrupt-select 1, a brown-out sets a sticky flag instead of causing a reset. `irq` is the OR of each flag ANDed with its enable.
- R11: With the low-voltage wake bit at 0, a low supply sets a sticky low-voltage flag. With the bit at 1, a low supply acts as a wakeup source and sets no flag.
- R12: A clear input drops its flag on the next edge, but a set condition in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok_a | input | 1 | Async flag: supply above power-on level |
| pdr_low_a | input | 1 | Async flag: supply at or below power-down level |
| bod_low_a | input | 1 | Async flag: supply at or below brown-out level |
| lvd_low_a | input | 1 | Async flag: supply below low-voltage threshold |
| ext_rst_n_a | input | 1 | Async external reset pin, active low |
| wake_req | input | 3 | Wakeup requests: timer, external line, wake pin |
| sleep_req | input | 1 | One-cycle request to enter the mode in sleep_mode |
| sleep_mode | input | 2 | 0 sleep, 1 DS1, 2 or 3 DS2 |
| cfg_bod_en | input | 1 | Brown-out detection enable |
| cfg_bod_irq_sel | input | 1 | Brown-out gives interrupt (1) or reset (0) |
| cfg_ldo_off | input | 1 | Regulator off bit for RUN/SLEEP |
| cfg_ldo_lcm | input | 1 | Regulator low-current bit for RUN/SLEEP |
| cfg_uldo_on | input | 1 | Keep standby regulator on in DS2 |
| cfg_lvd_wake | input | 1 | Low voltage acts as wakeup (1) or interrupt flag (0) |
| irq_en_bod | input | 1 | Brown-out interrupt enable |
| irq_en_lvd | input | 1 | Low-voltage interrupt enable |
| clr_bod | input | 1 | Write-one-to-clear for the brown-out flag |
| clr_lvd | input | 1 | Write-one-to-clear for the low-voltage flag |
| mldo_en | output | 1 | Main regulator enable |
| uldo_en | output | 1 | Standby regulator enable |
| uldo_lcm | output | 1 | Standby regulator low-current mode |
| sys_rst | output | 1 | Power/system reset |
| irq | output | 1 | Interrupt |
| wake_evt | output | 1 | One-cycle wakeup event |

## Verification
Each of the three sleep codes is entered and left through a different wakeup source. This shows that the mode decode and every wake path work on their own, and that DS2 follows the standby-on bit both ways. The low-voltage comparator is driven once with the wake bit clear and once with it set, which tells the interrupt path apart from the wakeup path. The brown-out comparator is driven under both select values, which tells the reset path apart from the sticky-flag path. Power-down is applied while running, and the outputs are sampled one edge and two edges later to pin down the synchronizer latency. Wake attempts are then made with the power-on flag low and then high, which shows the power-on gating.

// File: rtl/pwr_seq_pkg.sv
// Shared types and constants for the regulator sequencing controller.
// Assumes: state codes are internal only; mode codes are fixed by the port contract.
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_RUN   = 3'd1,
        PS_SLEEP = 3'd2,
        PS_DS1   = 3'd3,
        PS_DS2   = 3'd4
    } pwr_state_e;

    localparam int          NUM_ASYNC  = 5;
    localparam int          IDX_POR    = 0;
    localparam int          IDX_PDR    = 1;
    localparam int          IDX_BOD    = 2;
    localparam int          IDX_LVD    = 3;
    localparam int          IDX_RSTN   = 4;
    localparam logic [1:0]  MODE_SLEEP = 2'd0;
    localparam logic [1:0]  MODE_DS1   = 2'd1;
endpackage

// File: rtl/pwr_sync_bank.sv
// Bank of two-flop synchronizers, one per asynchronous input bit.
// Assumes: each input is a slow level; RST_VAL gives each bit's idle value.
module pwr_sync_bank #(
    parameter int              WIDTH   = 5,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
            end
        end

        assign dout[g] = sync_q;
    end
endmodule

// File: rtl/pwr_event_unit.sv
// Brown-out and low-voltage event handling: reset request, sticky flags, irq, wake.
// Assumes: inputs s_bod/s_lvd are already synchronized; clears are one-cycle pulses or levels.
module pwr_event_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic s_bod,
    input  logic s_lvd,
    input  logic cfg_bod_en,
    input  logic cfg_bod_irq_sel,
    input  logic cfg_lvd_wake,
    input  logic irq_en_bod,
    input  logic irq_en_lvd,
    input  logic clr_bod,
    input  logic clr_lvd,
    output logic bod_rst,
    output logic lvd_wake,
    output logic irq
);
    logic bod_set;
    logic lvd_set;
    logic bod_flag_q;
    logic lvd_flag_q;

    // Decode which response each comparator condition selects.
    always_comb begin
        bod_rst  = cfg_bod_en & ~cfg_bod_irq_sel & s_bod;
        bod_set  = cfg_bod_en &  cfg_bod_irq_sel & s_bod;
        lvd_set  = ~cfg_lvd_wake & s_lvd;
        lvd_wake =  cfg_lvd_wake & s_lvd;
    end

    // Sticky flags: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bod_flag_q <= 1'b0;
            lvd_flag_q <= 1'b0;
        end else begin
            bod_flag_q <= bod_set | (bod_flag_q & ~clr_bod);
            lvd_flag_q <= lvd_set | (lvd_flag_q & ~clr_lvd);
        end
    end

    // Interrupt is the enabled OR of the flags.
    always_comb irq = (bod_flag_q & irq_en_bod) | (lvd_flag_q & irq_en_lvd);

    AST_BOD_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bod_flag_q && !clr_bod) |=> bod_flag_q) else $error("bod flag lost"); // R10
    AST_CLR_WITHOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvd && !lvd_set) |=> !lvd_flag_q) else $error("lvd clear failed"); // R12
    AST_LVD_WAKE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lvd_wake && !lvd_flag_q) |=> !lvd_flag_q) else $error("lvd flag in wake mode"); // R11
    AST_BOD_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bod_irq_sel && !bod_flag_q && s_bod && cfg_bod_en) |=> bod_flag_q)
        else $error("bod irq path not taken"); // R10
endmodule

// File: rtl/pwr_reg_fsm.sv
// Power state machine and regulator enable decode.
// Assumes: all condition inputs are synchronous; power-down overrides every other input.
module pwr_reg_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_por,
    input  logic       s_pdr,
    input  logic       s_bod,
    input  logic       wake_any,
    input  logic       rst_fall,
    input  logic       sleep_req,
    input  logic [1:0] sleep_mode,
    input  logic       cfg_bod_en,
    input  logic       cfg_ldo_off,
    input  logic       cfg_ldo_lcm,
    input  logic       cfg_uldo_on,
    output logic       in_off,
    output logic       mldo_en,
    output logic       uldo_en,
    output logic       uldo_lcm,
    output logic       wake_evt
);
    pwr_state_e state_q;
    pwr_state_e state_d;
    logic       sleeping;
    logic       resume;
    logic       power_up;
    logic       wake_evt_q;

    // Qualifying events for leaving a low-power or off state.
    always_comb begin
        sleeping = (state_q == PS_SLEEP) || (state_q == PS_DS1) || (state_q == PS_DS2);
        resume   = s_por & (wake_any | rst_fall);
        power_up = s_por & (wake_any | rst_fall | (cfg_bod_en & ~s_bod));
    end

    // Next-state selection with power-down taking priority.
    always_comb begin
        state_d = state_q;
        if (s_pdr) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:   if (power_up) state_d = PS_RUN;
                PS_RUN: begin
                    if (sleep_req) begin
                        if (sleep_mode == MODE_SLEEP)    state_d = PS_SLEEP;
                        else if (sleep_mode == MODE_DS1) state_d = PS_DS1;
                        else                             state_d = PS_DS2;
                    end
                end
                PS_SLEEP, PS_DS1, PS_DS2: if (resume) state_d = PS_RUN;
                default:  state_d = PS_OFF;
            endcase
        end
    end

    // State and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_OFF;
            wake_evt_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            wake_evt_q <= sleeping & ~s_pdr & resume;
        end
    end

    // Regulator enables per state, forced off during power-down.
    always_comb begin
        mldo_en  = 1'b0;
        uldo_en  = 1'b0;
        uldo_lcm = 1'b0;
        unique case (state_q)
            PS_RUN, PS_SLEEP: begin
                mldo_en  = ~cfg_ldo_off & ~cfg_ldo_lcm;
                uldo_en  = ~cfg_ldo_off &  cfg_ldo_lcm;
                uldo_lcm = ~cfg_ldo_off &  cfg_ldo_lcm;
            end
            PS_DS1: begin
                uldo_en  = 1'b1;
                uldo_lcm = 1'b1;
            end
            PS_DS2: begin
                uldo_en  = cfg_uldo_on;
                uldo_lcm = cfg_uldo_on;
            end
            default: ;
        endcase
        if (s_pdr) begin
            mldo_en = 1'b0;
            uldo_en = 1'b0;
        end
    end

    assign in_off   = (state_q == PS_OFF);
    assign wake_evt = wake_evt_q;

    AST_PDR_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        s_pdr |-> (!mldo_en && !uldo_en)) else $error("regulator on in power-down"); // R2
    AST_PDR_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        s_pdr |=> (state_q == PS_OFF)) else $error("power-down did not reach OFF"); // R2
    AST_OFF_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_OFF) && !s_por) |=> (state_q == PS_OFF)) else $error("left OFF without POR"); // R3
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !s_pdr && s_por && wake_any) |=> (state_q == PS_RUN && wake_evt))
        else $error("wake did not resume"); // R8
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt) else $error("wake pulse too long"); // R8
    AST_DS_MAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_DS1) || (state_q == PS_DS2)) |-> !mldo_en) else $error("main on in deep sleep"); // R5
endmodule

// File: rtl/lp_reg_sequencer.sv
// Top of the regulator sequencing controller: synchronizers, reset-pin edge
// detect, event unit and power state machine.
// Assumes: comparator flags and the reset pin are asynchronous; everything else is synchronous to clk.
module lp_reg_sequencer
    import pwr_seq_pkg::*;
#(
    parameter int NUM_WAKE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_ok_a,
    input  logic                pdr_low_a,
    input  logic                bod_low_a,
    input  logic                lvd_low_a,
    input  logic                ext_rst_n_a,
    input  logic [NUM_WAKE-1:0] wake_req,
    input  logic                sleep_req,
    input  logic [1:0]          sleep_mode,
    input  logic                cfg_bod_en,
    input  logic                cfg_bod_irq_sel,
    input  logic                cfg_ldo_off,
    input  logic                cfg_ldo_lcm,
    input  logic                cfg_uldo_on,
    input  logic                cfg_lvd_wake,
    input  logic                irq_en_bod,
    input  logic                irq_en_lvd,
    input  logic                clr_bod,
    input  logic                clr_lvd,
    output logic                mldo_en,
    output logic                uldo_en,
    output logic                uldo_lcm,
    output logic                sys_rst,
    output logic                irq,
    output logic                wake_evt
);
    localparam logic [NUM_ASYNC-1:0] SYNC_RST = NUM_ASYNC'(1) << IDX_RSTN;

    logic [NUM_ASYNC-1:0] raw_flags;
    logic [NUM_ASYNC-1:0] s_flags;
    logic                 rstn_prev_q;
    logic                 rst_fall;
    logic                 lvd_wake;
    logic                 bod_rst;
    logic                 wake_any;
    logic                 in_off;

    assign raw_flags[IDX_POR]  = por_ok_a;
    assign raw_flags[IDX_PDR]  = pdr_low_a;
    assign raw_flags[IDX_BOD]  = bod_low_a;
    assign raw_flags[IDX_LVD]  = lvd_low_a;
    assign raw_flags[IDX_RSTN] = ext_rst_n_a;

    pwr_sync_bank #(
        .WIDTH   (NUM_ASYNC),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_flags),
        .dout  (s_flags)
    );

    // Previous synchronized reset-pin level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rstn_prev_q <= 1'b1;
        else        rstn_prev_q <= s_flags[IDX_RSTN];
    end

    assign rst_fall = rstn_prev_q & ~s_flags[IDX_RSTN];
    assign wake_any = (|wake_req) | lvd_wake;

    pwr_event_unit i_events (
        .clk             (clk),
        .rst_n           (rst_n),
        .s_bod           (s_flags[IDX_BOD]),
        .s_lvd           (s_flags[IDX_LVD]),
        .cfg_bod_en      (cfg_bod_en),
        .cfg_bod_irq_sel (cfg_bod_irq_sel),
        .cfg_lvd_wake    (cfg_lvd_wake),
        .irq_en_bod      (irq_en_bod),
        .irq_en_lvd      (irq_en_lvd),
        .clr_bod         (clr_bod),
        .clr_lvd         (clr_lvd),
        .bod_rst         (bod_rst),
        .lvd_wake        (lvd_wake),
        .irq             (irq)
    );

    pwr_reg_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_por       (s_flags[IDX_POR]),
        .s_pdr       (s_flags[IDX_PDR]),
        .s_bod       (s_flags[IDX_BOD]),
        .wake_any    (wake_any),
        .rst_fall    (rst_fall),
        .sleep_req   (sleep_req),
        .sleep_mode  (sleep_mode),
        .cfg_bod_en  (cfg_bod_en),
        .cfg_ldo_off (cfg_ldo_off),
        .cfg_ldo_lcm (cfg_ldo_lcm),
        .cfg_uldo_on (cfg_uldo_on),
        .in_off      (in_off),
        .mldo_en     (mldo_en),
        .uldo_en     (uldo_en),
        .uldo_lcm    (uldo_lcm),
        .wake_evt    (wake_evt)
    );

    // Power reset request from state, supply detectors and brown-out.
    always_comb sys_rst = in_off | s_flags[IDX_PDR] | ~s_flags[IDX_POR] | bod_rst;

    AST_RST_WHEN_NO_POR: assert property (@(posedge clk) disable iff (!rst_n)
        !s_flags[IDX_POR] |-> (sys_rst && !wake_evt)) else $error("no reset without POR"); // R9
    AST_RST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fall |=> !rst_fall) else $error("reset edge held"); // R1
endmodule

// File: tb/test_lp_reg_sequencer.sv
// Self-checking bench: behavioural reference model compared on every clock plus directed checks.
`timescale 1ns/1ps
module test_lp_reg_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_a = 0, pdr_a = 0, bod_a = 0, lvd_a = 0, rstn_a = 1;
    logic [2:0] wake_req = '0;
    logic sleep_req = 0;
    logic [1:0] sleep_mode = '0;
    logic c_bod_en = 0, c_bod_sel = 0, c_off = 0, c_lcm = 0, c_uldo = 0, c_lvdw = 0;
    logic e_bod = 0, e_lvd = 0, k_bod = 0, k_lvd = 0;
    logic mldo_en, uldo_en, uldo_lcm, sys_rst, irq, wake_evt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    lp_reg_sequencer i_lp_reg_sequencer (
        .clk(clk), .rst_n(rst_n), .por_ok_a(por_a), .pdr_low_a(pdr_a),
        .bod_low_a(bod_a), .lvd_low_a(lvd_a), .ext_rst_n_a(rstn_a),
        .wake_req(wake_req), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .cfg_bod_en(c_bod_en), .cfg_bod_irq_sel(c_bod_sel), .cfg_ldo_off(c_off),
        .cfg_ldo_lcm(c_lcm), .cfg_uldo_on(c_uldo), .cfg_lvd_wake(c_lvdw),
        .irq_en_bod(e_bod), .irq_en_lvd(e_lvd), .clr_bod(k_bod), .clr_lvd(k_lvd),
        .mldo_en(mldo_en), .uldo_en(uldo_en), .uldo_lcm(uldo_lcm),
        .sys_rst(sys_rst), .irq(irq), .wake_evt(wake_evt)
    );

    // Reference model: delay lines for async inputs, integer state 0 OFF 1 RUN 2 SLEEP 3 DS1 4 DS2.
    bit m_por_d[2], m_pdr_d[2], m_bod_d[2], m_lvd_d[2], m_rn_d[2];
    bit m_rn_prev;
    int m_st;
    bit m_bf, m_lf, m_wk;

    always @(posedge clk) begin
        started <= 1;
        cycles  <= cycles + 1;
        if (!rst_n) begin
            m_por_d <= '{0, 0}; m_pdr_d <= '{0, 0}; m_bod_d <= '{0, 0};
            m_lvd_d <= '{0, 0}; m_rn_d <= '{1, 1}; m_rn_prev <= 1;
            m_st <= 0; m_bf <= 0; m_lf <= 0; m_wk <= 0;
        end else begin
            automatic bit por  = m_por_d[1];
            automatic bit pdr  = m_pdr_d[1];
            automatic bit bod  = m_bod_d[1];
            automatic bit lvd  = m_lvd_d[1];
            automatic bit fall = m_rn_prev && !m_rn_d[1];
            automatic bit wany = (wake_req != 0) || (c_lvdw && lvd);
            automatic bit res  = por && (wany || fall);
            automatic int nx   = m_st;
            if (pdr) nx = 0;
            else if (m_st == 0) begin
                if (por && (wany || fall || (c_bod_en && !bod))) nx = 1;
            end else if (m_st == 1) begin
                if (sleep_req) nx = (sleep_mode == 0) ? 2 : (sleep_mode == 1) ? 3 : 4;
            end else if (res) nx = 1;
            m_wk <= (m_st >= 2) && !pdr && res;
            m_st <= nx;
            m_bf <= (c_bod_en && c_bod_sel && bod) || (m_bf && !k_bod);
            m_lf <= (!c_lvdw && lvd) || (m_lf && !k_lvd);
            m_por_d <= '{por_a, m_por_d[0]};
            m_pdr_d <= '{pdr_a, m_pdr_d[0]};
            m_bod_d <= '{bod_a, m_bod_d[0]};
            m_lvd_d <= '{lvd_a, m_lvd_d[0]};
            m_rn_d  <= '{rstn_a, m_rn_d[0]};
            m_rn_prev <= m_rn_d[1];
        end
    end

    task automatic cmp(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, nm, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            automatic bit pdr = m_pdr_d[1];
            automatic bit em = 0, eu = 0, el = 0;
            if (m_st == 1 || m_st == 2) begin
                em = !c_off && !c_lcm; eu = !c_off && c_lcm; el = eu;
            end else if (m_st == 3) begin
                eu = 1; el = 1;
            end else if (m_st == 4) begin
                eu = c_uldo; el = c_uldo;
            end
            if (pdr) begin em = 0; eu = 0; end
            cmp("R3", "mldo_en", mldo_en, em);
            cmp("R6", "uldo_en", uldo_en, eu);
            cmp("R7", "uldo_lcm", uldo_lcm, el);
            cmp("R9", "sys_rst", sys_rst,
                (m_st == 0) || pdr || !m_por_d[1] || (c_bod_en && !c_bod_sel && m_bod_d[1]));
            cmp("R10", "irq", irq, (m_bf && e_bod) || (m_lf && e_lvd));
            cmp("R8", "wake_evt", wake_evt, m_wk);
        end
    end

    task automatic drive_edge();
        @(posedge clk); #1;
    endtask
    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask
    task automatic go_sleep(logic [1:0] md);
        drive_edge(); sleep_req = 1; sleep_mode = md;
        drive_edge(); sleep_req = 0;
    endtask
    task automatic pulse_wake(int b);
        drive_edge(); wake_req[b] = 1'b1;
        drive_edge(); wake_req = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        settle(0);
        cmp("R9", "reset sys_rst", sys_rst, 1);
        cmp("R3", "reset mldo", mldo_en, 0);

        drive_edge(); por_a = 1;
        settle(6);
        cmp("R3", "no event stays off", mldo_en, 0);
        cmp("R9", "off keeps reset", sys_rst, 1);

        drive_edge(); c_bod_en = 1;
        settle(6);
        cmp("R3", "bod enable powers up", mldo_en, 1);
        cmp("R9", "run releases reset", sys_rst, 0);

        go_sleep(2'd0); settle(3);
        cmp("R4", "sleep keeps main", mldo_en, 1);
        cmp("R4", "sleep standby off", uldo_en, 0);
        pulse_wake(0); settle(3);

        go_sleep(2'd1); settle(3);
        cmp("R5", "ds1 main off", mldo_en, 0);
        cmp("R5", "ds1 standby on", uldo_en, 1);
        cmp("R5", "ds1 low current", uldo_lcm, 1);
        pulse_wake(1); settle(3);
        cmp("R8", "ext line wake", mldo_en, 1);

        drive_edge(); c_uldo = 1;
        go_sleep(2'd2); settle(3);
        cmp("R6", "ds2 retain on", uldo_en, 1);
        pulse_wake(2); settle(3);
        cmp("R8", "pin wake", mldo_en, 1);

        drive_edge(); c_uldo = 0;
        go_sleep(2'd3); settle(3);
        cmp("R6", "ds2 retain off", uldo_en, 0);
        cmp("R6", "ds2 main off", mldo_en, 0);
        drive_edge(); rstn_a = 0;
        settle(3);
        drive_edge(); rstn_a = 1;
        settle(3);
        cmp("R8", "reset pin fall wakes", mldo_en, 1);

        drive_edge(); c_lcm = 1;
        settle(1);
        cmp("R7", "lcm main off", mldo_en, 0);
        cmp("R7", "lcm standby on", uldo_en, 1);
        drive_edge(); c_off = 1;
        settle(1);
        cmp("R7", "off bit all off", uldo_en | mldo_en, 0);
        drive_edge(); c_off = 0; c_lcm = 0;

        drive_edge(); bod_a = 1;
        settle(3);
        cmp("R9", "bod reset", sys_rst, 1);
        drive_edge(); bod_a = 0; c_bod_sel = 1; e_bod = 1;
        settle(3);
        drive_edge(); bod_a = 1;
        settle(3);
        cmp("R10", "bod irq", irq, 1);
        cmp("R10", "bod no reset", sys_rst, 0);
        drive_edge(); bod_a = 0;
        settle(4);
        cmp("R10", "bod sticky", irq, 1);
        drive_edge(); k_bod = 1;
        drive_edge(); k_bod = 0;
        settle(0);
        cmp("R12", "bod clear", irq, 0);
        drive_edge(); bod_a = 1; k_bod = 1;
        settle(5);
        cmp("R12", "set beats clear", irq, 1);
        drive_edge(); bod_a = 0;
        settle(3);
        drive_edge(); k_bod = 0;

        drive_edge(); e_lvd = 1; lvd_a = 1;
        settle(3);
        cmp("R11", "lvd irq", irq, 1);
        drive_edge(); lvd_a = 0;
        settle(3);
        drive_edge(); k_lvd = 1;
        drive_edge(); k_lvd = 0;
        settle(0);
        cmp("R11", "lvd cleared", irq, 0);
        drive_edge(); c_lvdw = 1;
        go_sleep(2'd1); settle(2);
        cmp("R5", "ds1 before lvd", mldo_en, 0);
        drive_edge(); lvd_a = 1;
        settle(4);
        cmp("R11", "lvd wakes", mldo_en, 1);
        cmp("R11", "lvd no flag", irq, 0);
        drive_edge(); lvd_a = 0; c_lvdw = 0;
        settle(3);

        drive_edge(); pdr_a = 1;
        @(negedge clk); @(negedge clk);
        cmp("R1", "one edge later unchanged", mldo_en, 1);
        @(negedge clk);
        cmp("R1", "two edges later off", mldo_en, 0);
        cmp("R2", "pdr standby off", uldo_en, 0);
        cmp("R2", "pdr reset", sys_rst, 1);
        drive_edge(); por_a = 0;
        settle(3);
        drive_edge(); pdr_a = 0;
        settle(3);
        pulse_wake(0); settle(3);
        cmp("R3", "no por stays off", mldo_en, 0);
        drive_edge(); por_a = 1;
        settle(4);
        cmp("R3", "por plus bod powers up", mldo_en, 1);

        settle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule